// File: doc/BRIEF.md
# Single-Wire Wake and Sleep Sequencer

This block decides the power state of a small slave device that talks to its host over one shared wire. After power-up it sleeps and watches the deglitched bus level. A low pulse held for at least the filter time wakes it. It then holds the device core in reset for a fixed delay and reads two default bytes from a nonvolatile memory port: an address and speed byte, and a trim byte. Next it pulls the bus low for 1.391 bit-times to tell the host it is ready, and then enters the active state.

While active, bus low levels pass to the bit receiver as ordinary bits and never restart the wake sequence. An activity strobe from the bit receiver restarts an inactivity timer. When the timer runs out, the block goes back to sleep. The bus may idle high or low during that wait. An auto-sleep enable bit switches this timeout off. The enable is set at power-up and by a soft reset.

All timing is counted in cycles of the internal time base. The bit-time is a base period divided by a power of two that the loaded speed code selects.

Top module: `wake_sleep_seq`

## Requirements
- R1: After rst_n the block reports state code 0 (sleep), holds core_rst_n low, does not drive the bus, does not request memory and keeps rx_low low. The state codes are 0 sleep, 1 resetting, 2 loading, 3 ready pulse and 4 active.
- R2: In sleep, bus_in sampled low on DGL_CYC consecutive clock edges (DGL_US × CYC_PER_US) moves the state to resetting at the last of those edges. A shorter low pulse leaves the block asleep.
- R3: The resetting state lasts exactly RST_CYC cycles (RST_US × CYC_PER_US) whatever the bus level, so it may end while the wake pulse is still low. core_rst_n is high in every state after it.
- R4: In loading, the block reads address CFG_ADDR and then TRIM_ADDR over a request/valid handshake. Bits 7:2 of the first byte go to dev_addr, bits 1:0 go to bus_speed, and the second byte goes to trim. These outputs keep their values through sleep until the next load.
- R5: After loading, bus_drive_low is high for exactly floor(BT × 1391 / 1000) cycles, where BT = (BASE_BT_US × CYC_PER_US) >> bus_speed. The state then becomes active.
- R6: In active with no act_stb, the block returns to sleep after exactly IDLE_CYC cycles (IDLE_US × CYC_PER_US), with the bus held high or low. An act_stb restarts the full period.
- R7: Writing 0 to the auto-sleep enable (ctl_we with ctl_aslp_en low) stops the inactivity return to sleep.
- R8: The auto-sleep enable is 1 after rst_n and after a soft_rst pulse. After soft_rst the full IDLE_CYC period runs again.
- R9: In active, rx_low follows the inverted bus level for a low pulse of any width, and the state stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Power-up reset, active low |
| soft_rst | input | 1 | Soft reset pulse; sets auto-sleep enable |
| ctl_we | input | 1 | Write strobe for the auto-sleep enable bit |
| ctl_aslp_en | input | 1 | Value written to the auto-sleep enable |
| bus_in | input | 1 | Deglitched bus level, low is active |
| act_stb | input | 1 | One-cycle bus activity strobe from the bit receiver |
| mem_rdata | input | 8 | Byte returned by the nonvolatile memory |
| mem_valid | input | 1 | mem_rdata is valid this cycle |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | MEM_AW | Memory byte address |
| bus_drive_low | output | 1 | Pull the bus low (ready pulse) |
| rx_low | output | 1 | Bus low passed to the bit receiver while active |
| core_rst_n | output | 1 | Reset to the device core, active low |
| dev_addr | output | 6 | Loaded device address |
| bus_speed | output | 2 | Loaded speed code |
| trim | output | 8 | Loaded trim byte |
| state | output | 3 | Power state code |

## Verification
The assertions assume that mem_valid comes only while mem_req is high, that act_stb is a single-cycle pulse, and that the configured timing parameters are at least one cycle. The stimulus follows these rules. The bench memory model raises mem_valid for one cycle in answer to a pending request and never at any other time. Strobes and the soft reset are driven for exactly one cycle. Bus pulses are changed only on falling clock edges, so every low period has a known number of sampled edges.

// File: rtl/wss_pkg.sv
package wss_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP  = 3'd0,
    ST_RESET  = 3'd1,
    ST_LOAD   = 3'd2,
    ST_READY  = 3'd3,
    ST_ACTIVE = 3'd4
  } wss_state_e;

  localparam int unsigned RDY_NUM = 1391;
  localparam int unsigned RDY_DEN = 1000;

  // bit-time in cycles for a speed code: base period halved per code step
  function automatic int unsigned bit_time_cyc(input logic [1:0] code,
                                               input int unsigned base);
    return base >> code;
  endfunction

  // ready pulse length: 1.391 bit-times, rounded down
  function automatic int unsigned ready_cyc(input int unsigned bt);
    return (bt * RDY_NUM) / RDY_DEN;
  endfunction

endpackage

// File: rtl/wss_wake_filter.sv
module wss_wake_filter #(
  parameter int unsigned DGL_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic bus_in,
  output logic wake
);
  localparam int unsigned LW = $clog2(DGL_CYC + 1);

  logic [LW-1:0] lo_cnt;

  assign wake = armed && !bus_in && (lo_cnt == LW'(DGL_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         lo_cnt <= '0;
    else if (!armed || bus_in || wake)  lo_cnt <= '0;
    else                                lo_cnt <= lo_cnt + 1'b1;
  end

  // R2
  lo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cnt < LW'(DGL_CYC));

endmodule

// File: rtl/wss_cfg_loader.sv
module wss_cfg_loader #(
  parameter int unsigned MEM_AW    = 4,
  parameter int unsigned CFG_ADDR  = 0,
  parameter int unsigned TRIM_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_valid,
  output logic              mem_req,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              done,
  output logic [5:0]        dev_addr,
  output logic [1:0]        bus_speed,
  output logic [7:0]        trim
);
  logic second;

  assign mem_req  = en;
  assign mem_addr = second ? MEM_AW'(TRIM_ADDR) : MEM_AW'(CFG_ADDR);
  assign done     = en && mem_valid && second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second    <= 1'b0;
      dev_addr  <= '0;
      bus_speed <= '0;
      trim      <= '0;
    end else if (!en) begin
      second <= 1'b0;
    end else if (mem_valid) begin
      if (!second) begin
        dev_addr  <= mem_rdata[7:2];
        bus_speed <= mem_rdata[1:0];
        second    <= 1'b1;
      end else begin
        trim   <= mem_rdata;
        second <= 1'b0;
      end
    end
  end

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable({dev_addr, bus_speed, trim}));

endmodule

// File: rtl/wss_idle_timer.sv
module wss_idle_timer #(
  parameter int unsigned IDLE_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic act_stb,
  input  logic soft_rst,
  input  logic ctl_we,
  input  logic ctl_aslp_en,
  output logic aslp_en,
  output logic sleep_req
);
  localparam int unsigned IW = $clog2(IDLE_CYC + 1);

  logic [IW-1:0] idle_cnt;

  assign sleep_req = run && aslp_en && !act_stb && (idle_cnt == IW'(IDLE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        aslp_en <= 1'b1;
    else if (soft_rst) aslp_en <= 1'b1;
    else if (ctl_we)   aslp_en <= ctl_aslp_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        idle_cnt <= '0;
    else if (!run || act_stb || !aslp_en || sleep_req) idle_cnt <= '0;
    else                                               idle_cnt <= idle_cnt + 1'b1;
  end

  // R6
  idle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt < IW'(IDLE_CYC));

  // R8
  soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> aslp_en);

endmodule

// File: rtl/wake_sleep_seq.sv
module wake_sleep_seq
  import wss_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 10,
  parameter int unsigned DGL_US     = 20,
  parameter int unsigned RST_US     = 20,
  parameter int unsigned BASE_BT_US = 80,
  parameter int unsigned IDLE_US    = 1000000,
  parameter int unsigned MEM_AW     = 4,
  parameter int unsigned CFG_ADDR   = 0,
  parameter int unsigned TRIM_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              ctl_we,
  input  logic              ctl_aslp_en,
  input  logic              bus_in,
  input  logic              act_stb,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_valid,
  output logic              mem_req,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              bus_drive_low,
  output logic              rx_low,
  output logic              core_rst_n,
  output logic [5:0]        dev_addr,
  output logic [1:0]        bus_speed,
  output logic [7:0]        trim,
  output logic [2:0]        state
);
  localparam int unsigned DGL_CYC     = DGL_US * CYC_PER_US;
  localparam int unsigned RST_CYC     = RST_US * CYC_PER_US;
  localparam int unsigned BASE_BT_CYC = BASE_BT_US * CYC_PER_US;
  localparam int unsigned IDLE_CYC    = IDLE_US * CYC_PER_US;
  localparam int unsigned RDY_MAX     = ready_cyc(BASE_BT_CYC);
  localparam int unsigned PH_MAX      = (RDY_MAX > RST_CYC) ? RDY_MAX : RST_CYC;
  localparam int unsigned PH_W        = $clog2(PH_MAX + 1);

  wss_state_e  state_q;
  logic [PH_W-1:0] ph_cnt;

  // named internal events
  logic        wake;
  logic        load_done;
  logic        sleep_req;
  logic        aslp_en;
  logic [31:0] rdy_len;
  logic        rst_last;
  logic        rdy_last;

  assign rdy_len  = ready_cyc(bit_time_cyc(bus_speed, BASE_BT_CYC));
  assign rst_last = (ph_cnt == PH_W'(RST_CYC - 1));
  assign rdy_last = (32'(ph_cnt) == rdy_len - 32'd1);

  wss_wake_filter #(.DGL_CYC(DGL_CYC)) u_wake (
    .clk    (clk),
    .rst_n  (rst_n),
    .armed  (state_q == ST_SLEEP),
    .bus_in (bus_in),
    .wake   (wake)
  );

  wss_cfg_loader #(
    .MEM_AW   (MEM_AW),
    .CFG_ADDR (CFG_ADDR),
    .TRIM_ADDR(TRIM_ADDR)
  ) u_load (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (state_q == ST_LOAD),
    .mem_rdata(mem_rdata),
    .mem_valid(mem_valid),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .done     (load_done),
    .dev_addr (dev_addr),
    .bus_speed(bus_speed),
    .trim     (trim)
  );

  wss_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (state_q == ST_ACTIVE),
    .act_stb    (act_stb),
    .soft_rst   (soft_rst),
    .ctl_we     (ctl_we),
    .ctl_aslp_en(ctl_aslp_en),
    .aslp_en    (aslp_en),
    .sleep_req  (sleep_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SLEEP;
      ph_cnt  <= '0;
    end else begin
      case (state_q)
        ST_SLEEP: begin
          ph_cnt <= '0;
          if (wake) state_q <= ST_RESET;
        end
        ST_RESET: begin
          if (rst_last) begin
            state_q <= ST_LOAD;
            ph_cnt  <= '0;
          end else begin
            ph_cnt <= ph_cnt + 1'b1;
          end
        end
        ST_LOAD: begin
          ph_cnt <= '0;
          if (load_done) state_q <= ST_READY;
        end
        ST_READY: begin
          if (rdy_last) begin
            state_q <= ST_ACTIVE;
            ph_cnt  <= '0;
          end else begin
            ph_cnt <= ph_cnt + 1'b1;
          end
        end
        ST_ACTIVE: begin
          ph_cnt <= '0;
          if (sleep_req) state_q <= ST_SLEEP;
        end
        default: begin
          state_q <= ST_SLEEP;
          ph_cnt  <= '0;
        end
      endcase
    end
  end

  assign state         = state_q;
  assign core_rst_n    = (state_q != ST_SLEEP) && (state_q != ST_RESET);
  assign bus_drive_low = (state_q == ST_READY);
  assign rx_low        = (state_q == ST_ACTIVE) && !bus_in;

  // R2
  wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESET && $past(state_q) != ST_RESET) |-> $past(state_q) == ST_SLEEP);

  // R3
  reset_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESET) |-> (ph_cnt < PH_W'(RST_CYC)));

  // R5
  ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_drive_low) |-> $past(state_q) == ST_LOAD);

  // R7
  sleep_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && $past(state_q) == ST_ACTIVE) |-> $past(aslp_en));

  // R9
  active_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE) |=> (state_q == ST_ACTIVE || state_q == ST_SLEEP));

endmodule

// File: tb/wake_sleep_seq_bench.sv
module wake_sleep_seq_bench;

  localparam int CPU  = 2;
  localparam int DGL  = 20 * CPU;
  localparam int RST  = 20 * CPU;
  localparam int BASE = 80 * CPU;
  localparam int IDLE = 500 * CPU;

  // {cfg byte, trim byte, expected ready length}
  localparam logic [23:0] VEC [4] = '{
    {8'h5C, 8'hA1, 8'd222},
    {8'h31, 8'h3E, 8'd111},
    {8'hFE, 8'h00, 8'd55},
    {8'h07, 8'hFF, 8'd27}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       ctl_we = 1'b0;
  logic       ctl_aslp_en = 1'b0;
  logic       bus_in = 1'b1;
  logic       act_stb = 1'b0;
  logic [7:0] mem_rdata;
  logic       mem_valid;
  logic       mem_req;
  logic [3:0] mem_addr;
  logic       bus_drive_low;
  logic       rx_low;
  logic       core_rst_n;
  logic [5:0] dev_addr;
  logic [1:0] bus_speed;
  logic [7:0] trim;
  logic [2:0] state;

  logic [7:0] mem_img [2];

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wake_sleep_seq #(
    .CYC_PER_US(CPU), .DGL_US(20), .RST_US(20), .BASE_BT_US(80), .IDLE_US(500)
  ) u_wake_sleep_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ctl_we(ctl_we),
    .ctl_aslp_en(ctl_aslp_en), .bus_in(bus_in), .act_stb(act_stb),
    .mem_rdata(mem_rdata), .mem_valid(mem_valid), .mem_req(mem_req),
    .mem_addr(mem_addr), .bus_drive_low(bus_drive_low), .rx_low(rx_low),
    .core_rst_n(core_rst_n), .dev_addr(dev_addr), .bus_speed(bus_speed),
    .trim(trim), .state(state)
  );

  // memory model: one-cycle valid per pending request
  always @(posedge clk) begin
    if (!rst_n) mem_valid <= 1'b0;
    else        mem_valid <= mem_req && !mem_valid;
    mem_rdata <= mem_img[mem_addr[0]];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    int n;
    mem_img[0] = 8'h00;
    mem_img[1] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(state == 3'd0, "R1 state", state, 0);
    chk(core_rst_n == 1'b0, "R1 core_rst_n", core_rst_n, 0);
    chk(bus_drive_low == 1'b0 && mem_req == 1'b0, "R1 drive/req", bus_drive_low, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(state == 3'd0 && rx_low == 1'b0, "R1 sleep after release", state, 0);

    // R2 short pulse rejected
    bus_in = 1'b0;
    repeat (DGL - 1) @(negedge clk);
    bus_in = 1'b1;
    repeat (20) @(negedge clk);
    chk(state == 3'd0, "R2 short pulse ignored", state, 0);

    for (int i = 0; i < 4; i++) begin
      logic [7:0] cfg, trm;
      int exp_len, exp_idle;
      cfg = VEC[i][23:16];
      trm = VEC[i][15:8];
      exp_len = int'(VEC[i][7:0]);
      mem_img[0] = cfg;
      mem_img[1] = trm;

      // R2 wake pulse of exactly DGL sampled edges
      bus_in = 1'b0;
      repeat (DGL) @(negedge clk);
      chk(state == 3'd1, "R2 wake accepted", state, 1);
      if (i != 0) bus_in = 1'b1;

      // R3 reset duration, bus level independent
      n = 0;
      while (state == 3'd1) begin
        chk(core_rst_n == 1'b0, "R3 core held", core_rst_n, 0);
        n++;
        @(negedge clk);
      end
      chk(n == RST, "R3 reset length", n, RST);
      if (i == 0) begin
        chk(state == 3'd2 && bus_in == 1'b0, "R3 release while bus low", state, 2);
        bus_in = 1'b1;
      end
      chk(core_rst_n == 1'b1, "R3 core released", core_rst_n, 1);

      while (state == 3'd2) @(negedge clk);

      // R5 ready pulse length
      n = 0;
      while (bus_drive_low) begin
        n++;
        @(negedge clk);
      end
      chk(n == exp_len, "R5 ready length", n, exp_len);
      chk(state == 3'd4, "R5 active after ready", state, 4);

      // R4 configuration fields
      chk(dev_addr == cfg[7:2], "R4 dev_addr", dev_addr, int'(cfg[7:2]));
      chk(bus_speed == cfg[1:0], "R4 bus_speed", bus_speed, int'(cfg[1:0]));
      chk(trim == trm, "R4 trim", trim, int'(trm));

      if (i == 3) begin
        // R9 long low pulse while active is a bit, not a wake
        bus_in = 1'b0;
        repeat (100) @(negedge clk);
        chk(rx_low == 1'b1 && state == 3'd4, "R9 low passed while active", state, 4);
        bus_in = 1'b1;
        @(negedge clk);
        chk(rx_low == 1'b0 && state == 3'd4, "R9 rx released", rx_low, 0);
        // R7 disable auto-sleep
        ctl_aslp_en = 1'b0;
        ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
        repeat (3 * IDLE) @(negedge clk);
        chk(state == 3'd4, "R7 stays active when disabled", state, 4);
        // R8 soft reset re-enables
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        n = 0;
        while (state == 3'd4) begin
          n++;
          @(negedge clk);
        end
        chk(n == IDLE, "R8 sleep after soft reset", n, IDLE);
      end else begin
        // R6 inactivity timeout (R8 default enable after power-up)
        if (i == 1) bus_in = 1'b0;
        exp_idle = (i == 2) ? IDLE + 500 : IDLE;
        n = 0;
        while (state == 3'd4) begin
          n++;
          if (i == 2 && n == 500) act_stb = 1'b1;
          @(negedge clk);
          act_stb = 1'b0;
        end
        chk(n == exp_idle, "R6 idle length", n, exp_idle);
        bus_in = 1'b1;
      end
      chk(state == 3'd0, "R6 back to sleep", state, 0);
      repeat (5) @(negedge clk);
      chk(dev_addr == cfg[7:2] && trim == trm, "R4 held in sleep", trim, int'(trm));
    end

    finished = 1'b1;
    summary();
  end

endmodule